// File: doc/BRIEF.md
# Low-Power Bus and Pin Wake Detector

This block watches for two kinds of wake-up request while the transceiver sits in a low-power mode. The first comes from the bus. A low-power receiver supplies a digitized bus-dominant level. The block looks for a dominant phase, then a recessive phase, then a second dominant phase and a second recessive phase. Each phase must last at least a programmed number of clock cycles. When the second recessive phase reaches its minimum length, the block emits a one-cycle remote-wake pulse.

The second kind comes from a local wake pin. A change of level in either direction that then holds steady for a debounce window emits a one-cycle local-wake pulse. The debounced level also drives a pull-direction select for the current source on that pin: a settled high level selects pull-up, and a settled low level selects pull-down.

Both raw inputs pass through a synchronizer first. Detection is qualified by a low-power-mode input and by a block input that is high during the undervoltage waiting period. Local wakes are also suppressed while the power-up flag is set. All thresholds are parameters counted in clock cycles.

Top module: `lp_wake_detect`

## Requirements
- R1: After two dominant phases of at least DOM_MIN_CYC synchronized samples, each followed by a recessive phase of at least REC_MIN_CYC samples, `remote_wake` is high for exactly one cycle. It rises on the edge that takes the REC_MIN_CYC-th recessive sample of the second recessive phase. `bus_dom` = 1 means dominant.
- R2: A dominant phase that ends with fewer than DOM_MIN_CYC samples discards the pattern. The detector then waits for a new first dominant phase.
- R3: A recessive phase that is cut short by dominant before REC_MIN_CYC samples discards the pattern. The interrupting dominant phase is counted as a new first dominant phase.
- R4: After `wake_pin` changes level in either direction and stays at the new level, `local_wake` is high for exactly one cycle. This happens after the (SYNC_STAGES + DEB_CYC)-th rising edge that follows the change.
- R5: An excursion of `wake_pin` that lasts fewer than DEB_CYC samples before returning produces no `local_wake` pulse and leaves `wake_pull_up` unchanged.
- R6: `wake_pull_up` is 1 (pull-up) when the debounced level is high and 0 (pull-down) when it is low. It follows the debounced level in every mode and whatever the state of the qualifier inputs.
- R7: While `lp_mode` is low or `uv_block` is high, neither wake pulse is produced. The bus pattern detector also restarts from its idle state.
- R8: While `pwrup_flag` is high, `local_wake` stays low, while `wake_pull_up` still follows the pin.
- R9: The first debounced level after reset only sets the baseline. It produces no `local_wake` pulse, even when it differs from WAKE_RST_LVL.
- R10: During and right after reset, `remote_wake` and `local_wake` are 0 and `wake_pull_up` equals WAKE_RST_LVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_dom | input | 1 | Digitized low-power receiver output, 1 = dominant (asynchronous) |
| wake_pin | input | 1 | Local wake pin level (asynchronous) |
| lp_mode | input | 1 | High in standby, go-to-sleep and sleep modes |
| uv_block | input | 1 | High during the undervoltage waiting period |
| pwrup_flag | input | 1 | Power-up flag; blocks local wakes while high |
| remote_wake | output | 1 | One-cycle pulse on a valid bus wake pattern |
| local_wake | output | 1 | One-cycle pulse on a debounced pin edge |
| wake_pull_up | output | 1 | Pin current direction: 1 pull-up, 0 pull-down |

## Verification
The hardest case to reach is a pattern that is thrown away and then recovers. One example is a short first recessive phase whose interrupting dominant phase must then act as the first phase of a pattern that does complete. Another is a short second recessive phase that must not fire. The stimulus table builds these cases with phase lengths one sample below and exactly at the minimums. An optional fifth phase is appended so that the restarted sequence either completes or is left hanging. The other hard case is the baseline priming after reset. To reach it, the block is reset a second time while the pin is held high.

// File: rtl/lpw_pkg.sv
// Shared types and helpers for the low-power wake detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lpw_pkg;

    // States of the bus wake pattern sequencer
    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_DOM1 = 3'd1,
        SEQ_REC1 = 3'd2,
        SEQ_DOM2 = 3'd3,
        SEQ_REC2 = 3'd4
    } seq_state_t;

    // Larger of two integers, used for counter sizing
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpw_sync.sv
// Multi-stage flop synchronizer for asynchronous level inputs.
// Assumes: inputs are slow levels, not pulses; STAGES >= 1.
module lpw_sync #(
    parameter int           WIDTH   = 2,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            // Later stages shift the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/lpw_bus_seq.sv
// Bus wake pattern sequencer: dominant, recessive, dominant, recessive,
// each phase held for a minimum number of samples, then one-cycle hit.
// Assumes: dom is synchronous; DOM_MIN >= 1, REC_MIN >= 2.
module lpw_bus_seq
    import lpw_pkg::*;
#(
    parameter int DOM_MIN = 40,
    parameter int REC_MIN = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dom,
    output logic hit
);

    localparam int CNT_MAX = max2(DOM_MIN, REC_MIN);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] DOM_W = CW'(DOM_MIN);
    localparam logic [CW-1:0] REC_W = CW'(REC_MIN);
    localparam logic [CW-1:0] MAX_W = CW'(CNT_MAX);
    localparam logic [CW-1:0] ONE_W = CW'(1);

    seq_state_t      state, state_nx;
    logic [CW-1:0]   cnt, cnt_nx, cnt_inc;
    logic            hit_nx;

    // Saturating phase length increment
    always_comb cnt_inc = (cnt == MAX_W) ? cnt : cnt + ONE_W;

    // Next-state decode for the phase pattern
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        hit_nx   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (dom) begin
                    state_nx = SEQ_DOM1;
                    cnt_nx   = ONE_W;
                end
            end
            SEQ_DOM1, SEQ_DOM2: begin
                if (dom) begin
                    cnt_nx = cnt_inc;
                end else if (cnt >= DOM_W) begin
                    state_nx = (state == SEQ_DOM1) ? SEQ_REC1 : SEQ_REC2;
                    cnt_nx   = ONE_W;
                end else begin
                    state_nx = SEQ_IDLE;
                    cnt_nx   = '0;
                end
            end
            SEQ_REC1: begin
                if (!dom) begin
                    cnt_nx = cnt_inc;
                end else begin
                    state_nx = (cnt >= REC_W) ? SEQ_DOM2 : SEQ_DOM1;
                    cnt_nx   = ONE_W;
                end
            end
            SEQ_REC2: begin
                if (!dom) begin
                    if (cnt_inc >= REC_W) begin
                        state_nx = SEQ_IDLE;
                        cnt_nx   = '0;
                        hit_nx   = 1'b1;
                    end else begin
                        cnt_nx = cnt_inc;
                    end
                end else begin
                    state_nx = SEQ_DOM1;
                    cnt_nx   = ONE_W;
                end
            end
            default: begin
                state_nx = SEQ_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // State, counter and pulse registers; disabled means idle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            hit   <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            hit   <= hit_nx;
        end
    end

endmodule

// File: rtl/lpw_pin_debounce.sv
// Pin level debouncer: a level becomes settled after DEB_CYC equal
// consecutive samples; a settled change yields a one-cycle hit.
// Assumes: pin is synchronous; DEB_CYC >= 2. First settle after reset
// only primes the baseline.
module lpw_pin_debounce #(
    parameter int   DEB_CYC = 500,
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    output logic hit,
    output logic level
);

    localparam int CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] DEB_W = CW'(DEB_CYC);
    localparam logic [CW-1:0] ONE_W = CW'(1);

    logic          prev, primed, settle;
    logic [CW-1:0] run, run_nx;

    // Length of the current run of equal samples, and settle decision
    always_comb begin
        if (pin == prev) run_nx = (run == DEB_W) ? run : run + ONE_W;
        else             run_nx = ONE_W;
        settle = (run_nx >= DEB_W) && (!primed || (pin != level));
    end

    // Run tracking, settled level and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= RST_LVL;
            run    <= '0;
            level  <= RST_LVL;
            primed <= 1'b0;
            hit    <= 1'b0;
        end else begin
            prev <= pin;
            run  <= run_nx;
            hit  <= settle && primed && en;
            if (settle) begin
                level  <= pin;
                primed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lp_wake_detect.sv
// Top of the low-power wake detector: synchronizes the bus and pin
// inputs, runs the bus pattern sequencer and the pin debouncer, and
// qualifies both with mode, undervoltage block and power-up flag.
// Assumes: lp_mode, uv_block, pwrup_flag are synchronous to clk.
module lp_wake_detect #(
    parameter int   DOM_MIN_CYC  = 40,
    parameter int   REC_MIN_CYC  = 40,
    parameter int   DEB_CYC      = 500,
    parameter int   SYNC_STAGES  = 2,
    parameter logic WAKE_RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_dom,
    input  logic wake_pin,
    input  logic lp_mode,
    input  logic uv_block,
    input  logic pwrup_flag,
    output logic remote_wake,
    output logic local_wake,
    output logic wake_pull_up
);

    logic [1:0] raw_in, sync_in;
    logic       det_en, local_en;

    assign raw_in   = {wake_pin, bus_dom};
    assign det_en   = lp_mode & ~uv_block;
    assign local_en = det_en & ~pwrup_flag;

    lpw_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({WAKE_RST_LVL, 1'b0})
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    lpw_bus_seq #(
        .DOM_MIN (DOM_MIN_CYC),
        .REC_MIN (REC_MIN_CYC)
    ) i_bus_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (det_en),
        .dom   (sync_in[0]),
        .hit   (remote_wake)
    );

    lpw_pin_debounce #(
        .DEB_CYC (DEB_CYC),
        .RST_LVL (WAKE_RST_LVL)
    ) i_pin_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (local_en),
        .pin   (sync_in[1]),
        .hit   (local_wake),
        .level (wake_pull_up)
    );

endmodule

// File: rtl/lpw_checker.sv
// Property checker for lp_wake_detect, attached with bind.
// Assumes: DEB_CYC >= 2 and REC_MIN_CYC >= 2.
module lpw_checker (
    input logic clk,
    input logic rst_n,
    input logic lp_mode,
    input logic uv_block,
    input logic pwrup_flag,
    input logic remote_wake,
    input logic local_wake,
    input logic wake_pull_up
);

    // Remote pulse lasts a single cycle
    assert_remote_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |=> !remote_wake);

    // Local pulse lasts a single cycle
    assert_local_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |=> !local_wake);

    // A local pulse coincides with a change of pull direction
    assert_pull_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> (wake_pull_up != $past(wake_pull_up)));

    // Remote pulse only when enabled in the previous cycle
    assert_remote_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        remote_wake |-> $past(lp_mode && !uv_block));

    // Local pulse only when enabled in the previous cycle
    assert_local_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> $past(lp_mode && !uv_block));

    // Local pulse blocked by power-up flag
    assert_local_pwrup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        local_wake |-> $past(!pwrup_flag));

    // Never both pulses disabled check: outputs known out of reset
    assert_outputs_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({remote_wake, local_wake, wake_pull_up}));

endmodule

bind lp_wake_detect lpw_checker i_lpw_checker (.*);

// File: tb/test_lp_wake_detect.sv
module test_lp_wake_detect;

    localparam int DOM  = 4;
    localparam int REC  = 4;
    localparam int DEB  = 8;
    localparam int SYNC = 2;
    localparam int NVEC = 10;
    // fields: d1, r1, d2, r2, d3, lp_mode, uv_block, expected remote pulses
    localparam int VEC [NVEC][8] = '{
        '{ 4,  4,  4,  4, 0, 1, 0, 1},   // R1 exact minimums
        '{20, 20, 20, 20, 0, 1, 0, 1},   // R1 long phases
        '{ 3,  4,  4,  4, 0, 1, 0, 0},   // R2 short first dominant
        '{ 4,  4,  3,  4, 0, 1, 0, 0},   // R2 short second dominant
        '{ 3,  4,  4,  4, 4, 1, 0, 1},   // R2 restart then complete
        '{ 4,  3,  4,  4, 0, 1, 0, 0},   // R3 short first recessive
        '{ 4,  4,  4,  3, 4, 1, 0, 0},   // R3 short second recessive
        '{ 4,  3,  4,  4, 4, 1, 0, 1},   // R3 interrupting dominant counts as first
        '{ 4,  4,  4,  4, 0, 0, 0, 0},   // R7 not in low-power mode
        '{ 4,  4,  4,  4, 0, 1, 1, 0}    // R7 undervoltage block
    };

    logic clk = 1'b0;
    logic rst_n, bus_dom, wake_pin, lp_mode, uv_block, pwrup_flag;
    logic remote_wake, local_wake, wake_pull_up;
    int   checks = 0;
    int   errors = 0;
    int   rem_cnt = 0;
    int   loc_cnt = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    lp_wake_detect #(
        .DOM_MIN_CYC  (DOM),
        .REC_MIN_CYC  (REC),
        .DEB_CYC      (DEB),
        .SYNC_STAGES  (SYNC),
        .WAKE_RST_LVL (1'b0)
    ) i_lp_wake_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_dom      (bus_dom),
        .wake_pin     (wake_pin),
        .lp_mode      (lp_mode),
        .uv_block     (uv_block),
        .pwrup_flag   (pwrup_flag),
        .remote_wake  (remote_wake),
        .local_wake   (local_wake),
        .wake_pull_up (wake_pull_up)
    );

    // Pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (remote_wake) rem_cnt++;
        if (local_wake)  loc_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_phase(input logic v, input int n);
        bus_dom = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_dom = 1'b0; wake_pin = 1'b0;
        lp_mode = 1'b0; uv_block = 1'b0; pwrup_flag = 1'b0;
        wait_cyc(3);
        // R10 reset state
        check(remote_wake == 1'b0, "R10 remote_wake in reset", remote_wake, 0);
        check(local_wake == 1'b0, "R10 local_wake in reset", local_wake, 0);
        check(wake_pull_up == 1'b0, "R10 pull in reset", wake_pull_up, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check(wake_pull_up == 1'b0, "R10 pull after reset", wake_pull_up, 0);
        wait_cyc(DEB + 6);

        // Bus pattern table
        for (int v = 0; v < NVEC; v++) begin
            lp_mode = 1'b0;
            bus_phase(1'b0, 4);
            rem_cnt = 0;
            loc_cnt = 0;
            lp_mode  = VEC[v][5][0];
            uv_block = VEC[v][6][0];
            bus_phase(1'b1, VEC[v][0]);
            bus_phase(1'b0, VEC[v][1]);
            bus_phase(1'b1, VEC[v][2]);
            bus_phase(1'b0, VEC[v][3]);
            if (VEC[v][4] > 0) bus_phase(1'b1, VEC[v][4]);
            bus_phase(1'b0, 12);
            check(rem_cnt == VEC[v][7], $sformatf("R1/R2/R3/R7 vector %0d remote pulses", v),
                  rem_cnt, VEC[v][7]);
            check(loc_cnt == 0, $sformatf("R5 vector %0d no local pulse", v), loc_cnt, 0);
        end
        uv_block = 1'b0;
        lp_mode  = 1'b1;

        // R9: priming after reset with pin low produced no pulse so far
        check(wake_pull_up == 1'b0, "R9 baseline low", wake_pull_up, 0);

        // R4 exact latency of a rising edge
        loc_cnt = 0;
        wake_pin = 1'b1;
        wait_cyc(SYNC + DEB - 1);
        check(local_wake == 1'b0, "R4 pulse not early", local_wake, 0);
        wait_cyc(1);
        check(local_wake == 1'b1, "R4 pulse on time", local_wake, 1);
        check(wake_pull_up == 1'b1, "R6 pull-up after high", wake_pull_up, 1);
        wait_cyc(1);
        check(local_wake == 1'b0, "R4 pulse one cycle", local_wake, 0);

        // R5 short low excursion is ignored
        loc_cnt = 0;
        wake_pin = 1'b0;
        wait_cyc(DEB - 1);
        wake_pin = 1'b1;
        wait_cyc(DEB + 6);
        check(loc_cnt == 0, "R5 glitch no pulse", loc_cnt, 0);
        check(wake_pull_up == 1'b1, "R5 pull unchanged", wake_pull_up, 1);

        // R4 falling edge
        loc_cnt = 0;
        wake_pin = 1'b0;
        wait_cyc(DEB + 6);
        check(loc_cnt == 1, "R4 falling edge pulse", loc_cnt, 1);
        check(wake_pull_up == 1'b0, "R6 pull-down after low", wake_pull_up, 0);

        // R8 power-up flag blocks local wake, pull still follows
        loc_cnt = 0;
        pwrup_flag = 1'b1;
        wake_pin = 1'b1;
        wait_cyc(DEB + 6);
        check(loc_cnt == 0, "R8 no pulse with pwrup", loc_cnt, 0);
        check(wake_pull_up == 1'b1, "R8 pull follows with pwrup", wake_pull_up, 1);
        pwrup_flag = 1'b0;

        // R7 undervoltage block on local path
        loc_cnt = 0;
        uv_block = 1'b1;
        wake_pin = 1'b0;
        wait_cyc(DEB + 6);
        check(loc_cnt == 0, "R7 no local pulse while blocked", loc_cnt, 0);
        check(wake_pull_up == 1'b0, "R6 pull follows while blocked", wake_pull_up, 0);
        uv_block = 1'b0;

        // R7 outside low-power mode on local path
        loc_cnt = 0;
        lp_mode = 1'b0;
        wake_pin = 1'b1;
        wait_cyc(DEB + 6);
        check(loc_cnt == 0, "R7 no local pulse out of mode", loc_cnt, 0);
        check(wake_pull_up == 1'b1, "R6 pull follows out of mode", wake_pull_up, 1);

        // R9 reset with pin high: baseline set without a pulse
        lp_mode = 1'b1;
        rst_n = 1'b0;
        wait_cyc(3);
        check(wake_pull_up == 1'b0, "R10 pull back to reset level", wake_pull_up, 0);
        rst_n = 1'b1;
        loc_cnt = 0;
        wait_cyc(DEB + 8);
        check(loc_cnt == 0, "R9 no pulse when priming high", loc_cnt, 0);
        check(wake_pull_up == 1'b1, "R9 baseline high", wake_pull_up, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule